// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Master Slot Engine

This block drives a single-wire open-drain bus with a weak pullup and turns host commands into the four primitive bus operations: a bus reset with presence detection, a slot that writes a one, a slot that writes a zero, and a slot that reads a bit. Every operation is a fixed sequence of phases: an optional wait before the low pulse, the low pulse, a wait up to the sample point, and recovery. Each phase is counted in ticks from a prescaler that is restarted at the start of each operation, so every slot has the same length from one run to the next.

The host presents a command code, a speed select and a byte to send, then pulses `start`. The block is busy until the operation ends, which it signals with a one-cycle `done`. Two byte commands repeat the single-bit slots eight times back to back, least significant bit first. The byte read assembles the sampled bits into `rxByte`, which is valid when `byteDone` pulses. The bus pin is modelled as a pull-low enable `owDriveLow` and a line input `owIn`. The pad applies the pull-low, and the pullup or any slave sets the level while the enable is low.

Top module: `ow_master`

## Requirements
- R1: After reset, `busy`, `done`, `byteDone`, `owDriveLow`, `presence` and `rxByte` are all 0, and `readBit` is 1.
- R2: Command codes: 0 bus reset, 1 write-one slot, 2 write-zero slot, 3 read slot, 4 write byte, 5 read byte. A `start` with code 6 or 7 is ignored: `busy` stays 0, no low pulse appears and no `done` follows.
- R3: At standard speed (`overdrive`=0) a tick is 4·QDIV clocks (1 µs). Low pulse and total slot lengths in ticks are: write-one 6 of 70, write-zero 60 of 70, read 6 of 70, reset 480 of 960. There is no wait before the low pulse.
- R4: At overdrive speed a tick is QDIV clocks (0.25 µs). Low pulse and total slot lengths in ticks are: write-one 4 of 34, write-zero 30 of 40, read 4 of 36, reset 280 of 484. A reset waits 10 ticks before its low pulse.
- R5: A read slot samples the synchronised line 9 ticks (standard) or 4 ticks (overdrive) after the low pulse ends, and sets `readBit` to the sampled level. `readBit` holds until the next read sample.
- R6: A reset samples the line 70 ticks (standard) or 34 ticks (overdrive) after the low pulse ends. `presence` is set to 1 when the line was low (a device answered) and to 0 when it was high. It holds until the next reset.
- R7: A `start` while `busy` is 1 is ignored. The running operation keeps its length and pulses, and no extra operation follows.
- R8: The speed select and the transmit byte are captured when a command is accepted. Changes to them during an operation have no effect.
- R9: `busy` is 1 from the cycle after the accepting edge until the operation ends. `done` is a one-cycle pulse in the cycle after the last tick, when `busy` is already 0, so an operation of N ticks at period P shows `done` N·P cycles after the accepting edge.
- R10: A write byte sends eight slots back to back, least significant bit first, with no gap between them, each slot typed by its bit.
- R11: A read byte runs eight read slots back to back and places the first sampled bit at bit 0 of `rxByte`. `byteDone` pulses together with `done` at the end of either byte command, and never for a single-bit command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd | input | 3 | Command code |
| overdrive | input | 1 | Speed select, 1 = overdrive |
| txByte | input | 8 | Byte for the write-byte command |
| owIn | input | 1 | Bus line level (asynchronous) |
| owDriveLow | output | 1 | 1 = pull the bus line low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| readBit | output | 1 | Last read-slot sample |
| presence | output | 1 | 1 = device answered the last reset |
| rxByte | output | 8 | Assembled read byte |
| byteDone | output | 1 | One-cycle end-of-byte pulse |

## Verification
A wrong phase counter or a wrong phase transition shows up as a low pulse of the wrong width, or as an operation whose `done` arrives early or late. The low pulse error is visible at the falling edge of the enable inside the faulty slot. The timing error is visible at the end of that operation. A wrong slot type within a byte changes the pulse width of that bit, so the bit position of a fault can be read from the pulse sequence. Sampling at the wrong time, or a shift in the wrong direction, shows up in `readBit`, `presence` or `rxByte` as soon as the operation ends.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int CNT_W = 10;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  localparam logic [2:0] CMD_RESET  = 3'd0;
  localparam logic [2:0] CMD_WR1    = 3'd1;
  localparam logic [2:0] CMD_WR0    = 3'd2;
  localparam logic [2:0] CMD_READ   = 3'd3;
  localparam logic [2:0] CMD_WRBYTE = 3'd4;
  localparam logic [2:0] CMD_RDBYTE = 3'd5;

  typedef enum logic [1:0] {K_RST, K_W1, K_W0, K_RD} slot_e;
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_LOW, PH_SAMP, PH_REC} phase_e;

  typedef struct packed {
    logic active;
    logic clrPre;
    logic latch;
    logic driveLow;
    logic sampleRd;
    logic samplePres;
    logic shiftTx;
    logic finish;
    logic byteOp;
  } ctl_t;

  // Phase lengths in ticks of the selected speed
  function automatic logic [CNT_W-1:0] phaseLen(slot_e k, phase_e p, logic od);
    logic [CNT_W-1:0] v;
    v = '0;
    if (!od) begin
      case (p)
        PH_LOW:  case (k) K_RST: v = 10'd480; K_W0: v = 10'd60; default: v = 10'd6; endcase
        PH_SAMP: case (k) K_RST: v = 10'd70;  K_RD: v = 10'd9;  default: v = 10'd0; endcase
        PH_REC:  case (k) K_RST: v = 10'd410; K_W1: v = 10'd64; K_W0: v = 10'd10; default: v = 10'd55; endcase
        default: v = 10'd0;
      endcase
    end else begin
      case (p)
        PH_PRE:  v = (k == K_RST) ? 10'd10 : 10'd0;
        PH_LOW:  case (k) K_RST: v = 10'd280; K_W0: v = 10'd30; default: v = 10'd4; endcase
        PH_SAMP: case (k) K_RST: v = 10'd34;  K_RD: v = 10'd4;  default: v = 10'd0; endcase
        PH_REC:  case (k) K_RST: v = 10'd160; K_W1: v = 10'd30; K_W0: v = 10'd10; default: v = 10'd28; endcase
        default: v = 10'd0;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [2:0] cmd,
  input  logic overdrive,
  input  logic tick,
  input  logic txBit,
  input  logic odSel,
  output ctl_t ctl,
  output logic busy
);
  phase_e state;
  logic [CNT_W-1:0] cnt;
  logic [2:0] op;
  logic [BIT_IDX_W-1:0] bitIdx;
  slot_e kind;
  logic [CNT_W-1:0] curLen;
  logic accept, phaseEnd, byteOp, lastBit;

  always_comb begin
    case (op)
      CMD_RESET:  kind = K_RST;
      CMD_WR1:    kind = K_W1;
      CMD_WR0:    kind = K_W0;
      CMD_WRBYTE: kind = txBit ? K_W1 : K_W0;
      default:    kind = K_RD;
    endcase
  end

  assign curLen   = phaseLen(kind, state, odSel);
  assign busy     = (state != PH_IDLE);
  assign accept   = !busy && start && (cmd <= CMD_RDBYTE);
  assign phaseEnd = busy && tick && (cnt == curLen - CNT_W'(1));
  assign byteOp   = (op == CMD_WRBYTE) || (op == CMD_RDBYTE);
  assign lastBit  = !byteOp || (bitIdx == BIT_IDX_W'(BYTE_W - 1));

  always_comb begin
    ctl = '0;
    ctl.active   = busy;
    ctl.driveLow = (state == PH_LOW);
    ctl.byteOp   = byteOp;
    ctl.clrPre   = accept;
    ctl.latch    = accept;
    if (phaseEnd) begin
      if (state == PH_SAMP) begin
        ctl.sampleRd   = (kind == K_RD);
        ctl.samplePres = (kind == K_RST);
      end
      if (state == PH_REC) begin
        ctl.finish  = lastBit;
        ctl.shiftTx = !lastBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      op     <= '0;
      bitIdx <= '0;
    end else if (accept) begin
      op     <= cmd;
      bitIdx <= '0;
      cnt    <= '0;
      state  <= (cmd == CMD_RESET && overdrive) ? PH_PRE : PH_LOW;
    end else if (phaseEnd) begin
      cnt <= '0;
      case (state)
        PH_PRE:  state <= PH_LOW;
        PH_LOW:  state <= (kind == K_RD || kind == K_RST) ? PH_SAMP : PH_REC;
        PH_SAMP: state <= PH_REC;
        PH_REC: begin
          if (lastBit) state <= PH_IDLE;
          else begin
            bitIdx <= bitIdx + BIT_IDX_W'(1);
            state  <= PH_LOW;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end else if (busy && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7
  op_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(op)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < curLen));

  // R10
  bit_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !byteOp) |-> (bitIdx == '0));
endmodule

// File: rtl/owm_dp.sv
module owm_dp
  import owm_pkg::*;
#(
  parameter int QDIV = 25
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  logic overdrive,
  input  logic [BYTE_W-1:0] txByte,
  input  logic owIn,
  output logic tick,
  output logic txBit,
  output logic odSel,
  output logic owDriveLow,
  output logic done,
  output logic byteDone,
  output logic readBit,
  output logic presence,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int DIV_W = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [DIV_W-1:0] divCnt;
  logic [1:0] qCnt;
  logic qTick, sync1, sync2, odQ;
  logic [BYTE_W-1:0] txSh;

  assign qTick      = (divCnt == DIV_W'(QDIV - 1));
  assign tick       = qTick && (odQ || qCnt == 2'd3);
  assign txBit      = txSh[0];
  assign odSel      = odQ;
  assign owDriveLow = ctl.driveLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      qCnt   <= '0;
    end else if (ctl.clrPre || qTick) begin
      divCnt <= '0;
      qCnt   <= ctl.clrPre ? 2'd0 : qCnt + 2'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= owIn;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odQ      <= 1'b0;
      txSh     <= '0;
      readBit  <= 1'b1;
      presence <= 1'b0;
      rxByte   <= '0;
      done     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      done     <= ctl.finish;
      byteDone <= ctl.finish && ctl.byteOp;
      if (ctl.latch) begin
        odQ  <= overdrive;
        txSh <= txByte;
      end else if (ctl.shiftTx) begin
        txSh <= txSh >> 1;
      end
      if (ctl.sampleRd) begin
        readBit <= sync2;
        if (ctl.byteOp) rxByte <= {sync2, rxByte[BYTE_W-1:1]};
      end
      if (ctl.samplePres) presence <= !sync2;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  byte_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> done);

  // R8
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> $stable(odQ));
endmodule

// File: rtl/ow_master.sv
module ow_master
  import owm_pkg::*;
#(
  parameter int QDIV = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [2:0] cmd,
  input  logic overdrive,
  input  logic [7:0] txByte,
  input  logic owIn,
  output logic owDriveLow,
  output logic busy,
  output logic done,
  output logic readBit,
  output logic presence,
  output logic [7:0] rxByte,
  output logic byteDone
);
  ctl_t ctl;
  logic tick, txBit, odSel;

  owm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .overdrive(overdrive),
    .tick(tick), .txBit(txBit), .odSel(odSel), .ctl(ctl), .busy(busy)
  );

  owm_dp #(.QDIV(QDIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .overdrive(overdrive), .txByte(txByte),
    .owIn(owIn), .tick(tick), .txBit(txBit), .odSel(odSel),
    .owDriveLow(owDriveLow), .done(done), .byteDone(byteDone),
    .readBit(readBit), .presence(presence), .rxByte(rxByte)
  );
endmodule

// File: tb/ow_master_tb.sv
`timescale 1ns/1ps
module ow_master_tb;
  localparam int Q = 2;

  logic clk = 0, rstN = 0, start = 0, overdrive = 0;
  logic [2:0] cmd = 0;
  logic [7:0] txByte = 0;
  logic owIn, owDriveLow, busy, done, readBit, presence, byteDone;
  logic [7:0] rxByte;
  logic slaveLow = 0;

  int checks = 0, errors = 0;
  int expW[$];
  string expReq[$];

  bit slavePres = 0;
  logic [7:0] slaveBits = 8'hFF;
  int slaveIdx = 0;
  int benchKind = 2;
  bit benchOd = 0;

  always #5 clk = ~clk;
  assign owIn = !(owDriveLow || slaveLow);

  ow_master #(.QDIV(Q)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .overdrive(overdrive),
    .txByte(txByte), .owIn(owIn), .owDriveLow(owDriveLow), .busy(busy),
    .done(done), .readBit(readBit), .presence(presence), .rxByte(rxByte),
    .byteDone(byteDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 reset, 1 write-one, 2 write-zero, 3 read
  function automatic int lowT(input int k, input bit od);
    case (k)
      0: return od ? 280 : 480;
      2: return od ? 30 : 60;
      default: return od ? 4 : 6;
    endcase
  endfunction

  function automatic int totT(input int k, input bit od);
    case (k)
      0: return od ? 484 : 960;
      1: return od ? 34 : 70;
      2: return od ? 40 : 70;
      default: return od ? 36 : 70;
    endcase
  endfunction

  // Driver: pushes expected low pulses, runs the command, checks its end
  task automatic doOp(input logic [2:0] c, input bit od, input logic [7:0] tx,
                      input bit inject, input string req);
    int p, total, cnt, nb;
    p = od ? Q : 4 * Q;
    nb = (c >= 4) ? 8 : 1;
    total = 0;
    for (int i = 0; i < nb; i++) begin
      int k;
      case (c)
        3'd0: k = 0;
        3'd1: k = 1;
        3'd2: k = 2;
        3'd4: k = tx[i] ? 1 : 2;
        default: k = 3;
      endcase
      total += totT(k, od) * p;
      expW.push_back(lowT(k, od) * p);
      expReq.push_back(req);
    end
    benchKind = (c == 0) ? 0 : ((c == 3 || c == 5) ? 1 : 2);
    benchOd = od;
    slaveIdx = 0;
    @(negedge clk);
    cmd = c; overdrive = od; txByte = tx; start = 1;
    @(negedge clk);
    start = 0;
    cnt = 1;
    chk({req, " busy after start"}, busy, 1);
    while (!done && cnt < 100000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 10) begin
        start = 1; cmd = 3'd0; overdrive = !od; txByte = ~tx;
      end
      if (inject && cnt == 11) start = 0;
    end
    chk({req, " R9 done timing"}, cnt, total + 1);
    chk({req, " R9 busy low at done"}, busy, 0);
    chk({req, " R11 byteDone"}, byteDone, (c >= 4) ? 1 : 0);
    @(negedge clk);
    chk({req, " R9 done one cycle"}, done, 0);
    overdrive = 0;
  endtask

  // Monitor: measures each low pulse and compares with the queue
  initial begin
    int w;
    w = 0;
    forever begin
      @(negedge clk);
      if (owDriveLow) w++;
      else if (w > 0) begin
        if (expW.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected low pulse actual %0d expected none", w);
        end else begin
          string r;
          int e;
          e = expW.pop_front();
          r = expReq.pop_front();
          chk({r, " low width"}, w, e);
        end
        w = 0;
      end
    end
  end

  // Slave model: answers resets and read slots
  initial begin
    logic b;
    forever begin
      @(posedge owDriveLow);
      if (benchKind == 0) begin
        @(negedge owDriveLow);
        if (slavePres) begin
          repeat (benchOd ? 4 : 120) @(negedge clk);
          slaveLow = 1;
          repeat (benchOd ? 80 : 960) @(negedge clk);
          slaveLow = 0;
        end
      end else if (benchKind == 1) begin
        b = slaveBits[slaveIdx];
        slaveIdx++;
        if (!b) begin
          slaveLow = 1;
          repeat (benchOd ? 40 : 200) @(negedge clk);
          slaveLow = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 byteDone", byteDone, 0);
    chk("R1 line released", owDriveLow, 0);
    chk("R1 presence", presence, 0);
    chk("R1 readBit", readBit, 1);
    chk("R1 rxByte", rxByte, 0);

    slavePres = 1;
    doOp(3'd0, 0, 8'h00, 0, "R3 R6 std reset present");
    chk("R6 presence set", presence, 1);
    slavePres = 0;
    doOp(3'd1, 0, 8'h00, 0, "R3 std write one");
    doOp(3'd2, 0, 8'h00, 0, "R3 std write zero");
    slaveBits = 8'h00;
    doOp(3'd3, 0, 8'h00, 0, "R3 R5 std read zero");
    chk("R5 readBit zero", readBit, 0);
    chk("R6 presence holds over read", presence, 1);
    doOp(3'd1, 0, 8'h00, 0, "R5 write between reads");
    chk("R5 readBit holds", readBit, 0);
    slaveBits = 8'hFF;
    doOp(3'd3, 0, 8'h00, 0, "R5 std read one");
    chk("R5 readBit one", readBit, 1);
    doOp(3'd0, 0, 8'h00, 0, "R6 std reset absent");
    chk("R6 presence clear", presence, 0);

    slavePres = 1;
    doOp(3'd0, 1, 8'h00, 0, "R4 R6 od reset present");
    chk("R6 od presence", presence, 1);
    doOp(3'd1, 1, 8'h00, 0, "R4 od write one");
    doOp(3'd2, 1, 8'h00, 0, "R4 od write zero");
    slaveBits = 8'h00;
    doOp(3'd3, 1, 8'h00, 0, "R4 R5 od read zero");
    chk("R5 od readBit", readBit, 0);

    doOp(3'd4, 0, 8'hA5, 0, "R10 std write byte");
    slaveBits = 8'h3C;
    doOp(3'd5, 1, 8'h00, 0, "R11 od read byte");
    chk("R11 rxByte", rxByte, 8'h3C);
    slaveBits = 8'hC6;
    doOp(3'd5, 0, 8'h00, 0, "R11 std read byte");
    chk("R11 std rxByte", rxByte, 8'hC6);

    doOp(3'd2, 0, 8'h00, 1, "R7 R8 start ignored while busy");
    doOp(3'd4, 1, 8'h1E, 1, "R8 byte and speed captured");

    @(negedge clk);
    cmd = 3'd6; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 code 6 not busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R2 code 6 no done", done, 0);
    chk("R2 code 6 line", owDriveLow, 0);
    cmd = 3'd7; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 code 7 not busy", busy, 0);

    repeat (10) @(negedge clk);
    chk("R10 all pulses seen", expW.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule